// File: doc/BRIEF.md
# Longword Write Sequencer for a Halfword Bus Port

This block is a bus master that carries one 32-bit write over a port whose data path is only 16 bits wide. A requester hands it an address and a 32-bit word. The block then runs two halfword phases on the bus. It presents the upper half of the word at the given address first, and the lower half at that address plus two. A transfer-start strobe opens the transfer. In every word phase the block keeps driving address and data until the slave's acknowledge input is seen high on a rising clock edge. There is no timeout, so a slow slave simply adds wait states.

After the second acknowledge, one closing clock takes the data drivers off the bus and pulses `done`. A request whose address is not a multiple of four is refused with a one-clock `err` pulse and produces no bus activity. Requests are taken only while `req_ready` is high, which is the idle state. Halfword data goes out on `bus_data`, which stands for the upper data lines D[31:16]. Its output enable `bus_data_oe` marks when those lines are driven; when the enable is low the lines are meant to float.

Top module: `lws_longword_master`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `req_ready` is 1, `bus_start`, `bus_data_oe`, `done` and `err` are 0, and `bus_addr` and `bus_data` are 0.
- R2: A request (`req_valid` high at a rising edge) is taken only when `req_ready` is 1. While a transfer is under way, `req_valid` has no effect on the address, data, or any other output.
- R3: An aligned request at edge E makes `bus_start` 1 for exactly the one cycle after E. In that cycle `bus_addr` equals `req_addr`, `bus_data` equals `req_data[31:16]`, `bus_data_oe` is 1 and `req_ready` is 0.
- R4: `bus_ta` is ignored in the first two cycles of a transfer (the start cycle and the cycle after it). From the third cycle on, it is sampled at every rising edge. Each edge with `bus_ta` low keeps the current address and halfword on the bus for another cycle.
- R5: The edge that samples `bus_ta` high in the first word phase moves `bus_addr` to `req_addr + 2` and `bus_data` to `req_data[15:0]`.
- R6: The second word phase also waits for as long as `bus_ta` is low. From the `bus_start` cycle to the `done` cycle, the count is exactly 4 + w1 + w2 cycles, where w1 and w2 are the numbers of sampled low-acknowledge edges in the two word phases.
- R7: The edge that samples `bus_ta` high in the second word phase leads to one release cycle. In it, `bus_data_oe` is 0 and `done` is 1. In the cycle after that, `req_ready` is 1 again.
- R8: A request with `req_addr[1:0]` not equal to 0 taken at edge E sets `err` to 1 for the single cycle after E. It produces no `bus_start` and no `bus_data_oe`, and `req_ready` stays 1.
- R9: Whenever `bus_data_oe` is 0, both `bus_addr` and `bus_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request |
| req_addr | input | 32 | Byte address of the longword; must be a multiple of 4 |
| req_data | input | 32 | Longword to write |
| req_ready | output | 1 | High while idle and able to take a request |
| bus_addr | output | 32 | Bus address; 0 when the bus is not driven |
| bus_data | output | 16 | Halfword for data lines D[31:16]; 0 when not driven |
| bus_data_oe | output | 1 | Output enable of the data lines |
| bus_start | output | 1 | One-cycle transfer-start strobe |
| bus_ta | input | 1 | Slave acknowledge, active high |
| done | output | 1 | One-cycle pulse in the release cycle |
| err | output | 1 | One-cycle pulse for a misaligned request |

## Verification
Each accepted request shows its effect one cycle after the accepting edge: the start strobe with the first halfword, or the `err` pulse. A sampled acknowledge changes the address and halfword, or enters the release cycle, one cycle after the edge that samples it, and `req_ready` comes back one cycle after `done`. The bench drives inputs on falling edges. A behavioural model advances on each rising edge from the same inputs, and every output is compared with it at the next falling edge. This lines up each expectation with the cycle in which the registered state shows it. A separate monitor measures the distance from start strobe to `done` against the wait counts the bench chose.

// File: rtl/lws_pkg.sv
package lws_pkg;

    // Sequencer phases of one longword transfer
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_START   = 3'd1,
        PH_SETUP   = 3'd2,
        PH_BEAT    = 3'd3,
        PH_RELEASE = 3'd4
    } phase_e;

    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_PORT_W = 16;

    // Control view handed from the sequencer to the payload stage
    typedef struct packed {
        phase_e phase;
        logic   last_beat;
    } seq_ctrl_t;

    function automatic logic phase_drives_bus(input phase_e ph);
        return (ph == PH_START) || (ph == PH_SETUP) || (ph == PH_BEAT);
    endfunction

    function automatic int unsigned safe_clog2(input int unsigned v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/lws_req_check.sv
module lws_req_check
    import lws_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              idle,
    output logic              take_ok,
    output logic              take_bad
);
    localparam int unsigned LW_BYTES   = DATA_W / 8;
    localparam int unsigned ALIGN_BITS = safe_clog2(LW_BYTES);

    logic aligned;

    always_comb begin
        aligned  = (req_addr[ALIGN_BITS-1:0] == '0);
        take_ok  = req_valid && idle && aligned;
        take_bad = req_valid && idle && !aligned;
    end

endmodule

// File: rtl/lws_seq_fsm.sv
module lws_seq_fsm
    import lws_pkg::*;
#(
    parameter int unsigned BEATS = 2,
    localparam int unsigned BW   = safe_clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic          ta,
    output seq_ctrl_t     ctrl,
    output logic [BW-1:0] beat
);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    phase_e        phase_q, phase_d;
    logic [BW-1:0] beat_q, beat_d;

    always_comb begin
        phase_d = phase_q;
        beat_d  = beat_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start_req) begin
                    phase_d = PH_START;
                    beat_d  = '0;
                end
            end
            PH_START:  phase_d = PH_SETUP;
            PH_SETUP:  phase_d = PH_BEAT;
            PH_BEAT: begin
                if (ta) begin
                    if (beat_q == LAST) begin
                        phase_d = PH_RELEASE;
                    end else begin
                        beat_d = beat_q + BW'(1);
                    end
                end
            end
            PH_RELEASE: phase_d = PH_IDLE;
            default:    phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            beat_q  <= '0;
        end else begin
            phase_q <= phase_d;
            beat_q  <= beat_d;
        end
    end

    always_comb begin
        ctrl.phase     = phase_q;
        ctrl.last_beat = (beat_q == LAST);
        beat           = beat_q;
    end

endmodule

// File: rtl/lws_payload.sv
module lws_payload
    import lws_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned PORT_W = DEF_PORT_W,
    localparam int unsigned BEATS = DATA_W / PORT_W,
    localparam int unsigned BW    = safe_clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  seq_ctrl_t         ctrl,
    input  logic [BW-1:0]     beat,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [PORT_W-1:0] bus_data,
    output logic              bus_data_oe,
    output logic              bus_start
);
    localparam int unsigned STEP = PORT_W / 8;

    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] word_q;
    logic [PORT_W-1:0] halves [BEATS];
    logic              drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            word_q <= '0;
        end else if (load) begin
            base_q <= req_addr;
            word_q <= req_data;
        end
    end

    // Most significant slice goes out first
    for (genvar g = 0; g < BEATS; g++) begin : g_slice
        assign halves[g] = word_q[DATA_W-1-g*PORT_W -: PORT_W];
    end

    always_comb begin
        drive       = phase_drives_bus(ctrl.phase);
        bus_data_oe = drive;
        bus_start   = (ctrl.phase == PH_START);
        bus_addr    = drive ? (base_q + ADDR_W'(beat) * ADDR_W'(STEP)) : '0;
        bus_data    = drive ? halves[beat] : '0;
    end

endmodule

// File: rtl/lws_longword_master.sv
module lws_longword_master
    import lws_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned PORT_W = DEF_PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [PORT_W-1:0] bus_data,
    output logic              bus_data_oe,
    output logic              bus_start,
    input  logic              bus_ta,
    output logic              done,
    output logic              err
);
    localparam int unsigned BEATS = DATA_W / PORT_W;
    localparam int unsigned BW    = safe_clog2(BEATS);

    seq_ctrl_t     ctrl;
    logic [BW-1:0] beat;
    logic          take_ok;
    logic          take_bad;
    logic          idle;
    logic          err_q;

    assign idle = (ctrl.phase == PH_IDLE);

    lws_req_check #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_check (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .idle      (idle),
        .take_ok   (take_ok),
        .take_bad  (take_bad)
    );

    lws_seq_fsm #(
        .BEATS (BEATS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_req (take_ok),
        .ta        (bus_ta),
        .ctrl      (ctrl),
        .beat      (beat)
    );

    lws_payload #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PORT_W (PORT_W)
    ) u_payload (
        .clk         (clk),
        .rst         (rst),
        .load        (take_ok),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .ctrl        (ctrl),
        .beat        (beat),
        .bus_addr    (bus_addr),
        .bus_data    (bus_data),
        .bus_data_oe (bus_data_oe),
        .bus_start   (bus_start)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= take_bad;
        end
    end

    assign req_ready = idle;
    assign done      = (ctrl.phase == PH_RELEASE);
    assign err       = err_q;

endmodule

// File: rtl/lws_chk.sv
module lws_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned PORT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PORT_W-1:0] bus_data,
    input logic              bus_data_oe,
    input logic              bus_start,
    input logic              bus_ta,
    input logic              done,
    input logic              err
);
    localparam int unsigned STEP = PORT_W / 8;

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bus_start |=> !bus_start);  // R3

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        bus_start |-> ($past(req_ready) && $past(req_valid)));  // R2

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bus_data_oe && !bus_ta) |=> (bus_data_oe && $stable(bus_addr) && $stable(bus_data)));  // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (bus_data_oe && $past(bus_data_oe) && (bus_addr != $past(bus_addr)))
            |-> (bus_addr == $past(bus_addr) + ADDR_W'(STEP)));  // R5

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(bus_data_oe) && $past(bus_ta) && !bus_data_oe));  // R7

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        err |-> (!bus_start && !bus_data_oe && req_ready));  // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_data_oe |-> ((bus_addr == '0) && (bus_data == '0)));  // R9

endmodule

bind lws_longword_master lws_chk #(
    .ADDR_W (ADDR_W),
    .PORT_W (PORT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .bus_addr    (bus_addr),
    .bus_data    (bus_data),
    .bus_data_oe (bus_data_oe),
    .bus_start   (bus_start),
    .bus_ta      (bus_ta),
    .done        (done),
    .err         (err)
);

// File: tb/lws_longword_master_tb_top.sv
`timescale 1ns/1ps
module lws_longword_master_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        req_ready;
    logic [31:0] bus_addr;
    logic [15:0] bus_data;
    logic        bus_data_oe;
    logic        bus_start;
    logic        bus_ta = 1'b0;
    logic        done;
    logic        err;

    always #2 clk = ~clk;  // 250 MHz

    lws_longword_master dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_ready(req_ready), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_data_oe(bus_data_oe), .bus_start(bus_start),
        .bus_ta(bus_ta), .done(done), .err(err)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int st_cyc  = 0;
    int cur_w1  = 0;
    int cur_w2  = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (cycle %0d)",
                     tag, what, act, exp, cyc);
        end
    endtask

    // Behavioural reference: mode 0 idle, 1 on bus, 2 release
    int          m_mode = 0;
    int          m_t    = 0;
    int          m_word = 0;
    bit          m_err  = 0;
    logic [31:0] m_base = '0;
    logic [31:0] m_data = '0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_mode = 0; m_t = 0; m_word = 0; m_err = 0; m_base = '0; m_data = '0;
        end else begin
            m_err = 0;
            case (m_mode)
                0: if (req_valid) begin
                    if (req_addr[1:0] != 2'b00) m_err = 1;
                    else begin
                        m_mode = 1; m_t = 1; m_word = 0;
                        m_base = req_addr; m_data = req_data;
                    end
                end
                1: begin
                    if (m_t < 3) m_t++;
                    else if (bus_ta) begin
                        if (m_word == 0) m_word = 1;
                        else m_mode = 2;
                    end
                end
                default: m_mode = 0;
            endcase
        end
    end

    // Compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            logic [31:0] ea;
            logic [15:0] ed;
            ea = (m_mode == 1) ? m_base + ((m_word == 1) ? 32'd2 : 32'd0) : 32'd0;
            ed = (m_mode != 1) ? 16'd0 : ((m_word == 1) ? m_data[15:0] : m_data[31:16]);
            check(req_ready == (m_mode == 0), "R2", "req_ready", req_ready, m_mode == 0);
            check(bus_start == (m_mode == 1 && m_t == 1), "R3", "bus_start",
                  bus_start, m_mode == 1 && m_t == 1);
            check(bus_data_oe == (m_mode == 1), "R4", "bus_data_oe", bus_data_oe, m_mode == 1);
            check(bus_addr == ea, (m_word == 1) ? "R5" : "R4", "bus_addr", bus_addr, ea);
            check(bus_data == ed, (m_mode != 1) ? "R9" : "R5", "bus_data", bus_data, ed);
            check(done == (m_mode == 2), "R7", "done", done, m_mode == 2);
            check(err == m_err, "R8", "err", err, m_err);
            if (bus_start) st_cyc = cyc;
            if (done)
                check(cyc - st_cyc == 4 + cur_w1 + cur_w2, "R6", "start-to-done cycles",
                      cyc - st_cyc, 4 + cur_w1 + cur_w2);
        end
    end

    task automatic xfer(input logic [31:0] a, input logic [31:0] d,
                        input int w1, input int w2, input bit noisy);
        cur_w1 = w1; cur_w2 = w2;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d;
        @(negedge clk);               // start cycle
        req_valid = noisy; req_addr = 32'h0000_2000; req_data = 32'h1111_2222;
        bus_ta = noisy;               // R4: not sampled here
        @(negedge clk);               // setup cycle
        bus_ta = noisy;
        @(negedge clk);               // first sampling cycle
        req_valid = 1'b0;
        for (int i = 0; i < w1; i++) begin bus_ta = 1'b0; @(negedge clk); end
        bus_ta = 1'b1; @(negedge clk);
        for (int i = 0; i < w2; i++) begin
            bus_ta = 1'b0; req_valid = noisy; @(negedge clk);
        end
        req_valid = 1'b0;
        bus_ta = 1'b1; @(negedge clk);  // release cycle follows
        bus_ta = 1'b0; @(negedge clk);
    endtask

    task automatic bad_req(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = 32'hBAD0_BAD0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1 && bus_start == 1'b0 && bus_data_oe == 1'b0 &&
              done == 1'b0 && err == 1'b0, "R1", "control outputs in reset",
              {req_ready, bus_start, bus_data_oe, done, err}, 5'b10000);
        check(bus_addr == 32'd0 && bus_data == 16'd0, "R1", "bus in reset",
              {bus_addr, bus_data}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && bus_data_oe == 1'b0, "R1", "after reset",
              {req_ready, bus_data_oe}, 2'b10);

        xfer(32'h0000_1000, 32'hDEAD_BEEF, 0, 0, 1'b0);
        xfer(32'h0000_4A0C, 32'h1234_5678, 3, 1, 1'b1);
        xfer(32'h0000_0010, 32'hCAFE_F00D, 0, 5, 1'b1);
        xfer(32'hFFFF_FFFC, 32'hA5A5_5A5A, 7, 0, 1'b0);
        bad_req(32'h0000_1002);
        bad_req(32'h0000_1001);
        bad_req(32'h0000_1003);
        xfer(32'h0000_0000, 32'h0001_FFFE, 2, 2, 1'b1);

        // R8 then an aligned request on the very next cycle
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_0301; req_data = 32'h0;
        @(negedge clk);
        check(err == 1'b1 && req_ready == 1'b1, "R8", "err pulse, still ready",
              {err, req_ready}, 2'b11);
        req_addr = 32'h0000_0300; req_data = 32'h7777_8888;
        @(negedge clk);
        req_valid = 1'b0;
        check(bus_start == 1'b1 && bus_data == 16'h7777, "R3", "start after refusal",
              {bus_start, bus_data}, {1'b1, 16'h7777});
        cur_w1 = 0; cur_w2 = 0;
        @(negedge clk);
        @(negedge clk);
        bus_ta = 1'b1;
        @(negedge clk);
        check(bus_addr == 32'h0000_0302 && bus_data == 16'h8888, "R5", "second halfword",
              {bus_addr, bus_data}, {32'h0000_0302, 16'h8888});
        @(negedge clk);
        bus_ta = 1'b0;
        check(done == 1'b1 && bus_data_oe == 1'b0, "R7", "release cycle",
              {done, bus_data_oe}, 2'b10);
        @(negedge clk);
        check(req_ready == 1'b1 && done == 1'b0, "R7", "ready after done",
              {req_ready, done}, 2'b10);
        repeat (3) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected end");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule